// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Read Controller

This block is the host-side master for 93-series serial EEPROMs that use a chip select, a serial clock, a data line into the memory and a data line out of it. A single-cycle request selects one of four operations: read a 16-bit word, read a byte, enable writes or disable writes. The block then raises chip select, clocks out a start bit, an opcode and the address most significant bit first, clocks in the data most significant bit first and drops chip select. The result is returned right-aligned on a 16-bit output together with a one-cycle completion strobe.

The memory answers every read with one zero bit ahead of the data. Normally that bit appears during the last address clock and is absorbed there. Some host boards instead delay it by a full clock. For those boards a per-request option inserts one extra clock pulse between the last command bit and the first data sample, so the data still lines up. The serial clock rate comes from a programmable half-period counted in system clock cycles.

Top module: `mw_eeprom_rd`

## Requirements
- R1: A word read (req_op = 0) sends 3+ADDR_W bits on mw_di: the bits 1,1,0 followed by req_addr[ADDR_W-1:0] most significant bit first. It then clocks 16 data bits from mw_do, most significant first, into rd_data.
- R2: A byte read (req_op = 1) sends 1,1,0 followed by the ADDR_W+1 bits of req_addr. It reads 8 data bits and returns them in rd_data[7:0], with rd_data[15:8] zero.
- R3: mw_do is sampled just before each rising mw_sk edge of the data phase. The result appears in rd_data in the same cycle as a done strobe that lasts exactly one cycle, and mw_di stays 0 during the data phase.
- R4: When req_quirk is set on a read, exactly one extra mw_sk pulse lies between the last command bit and the first data sample. A transfer therefore has command bits + 1 + data bits pulses. With req_quirk clear it has command bits + data bits pulses.
- R5: The write-enable request (req_op = 2) sends the bits 1,0,0,1,1 followed by ADDR_W-2 zeros. The write-disable request (req_op = 3) sends 1,0,0,0,0 followed by ADDR_W-2 zeros. Neither has a data phase, both ignore req_quirk, and both leave rd_data unchanged.
- R6: mw_di changes only while mw_sk is low, and mw_cs changes only while mw_sk is low.
- R7: Each high and each low phase of mw_sk lasts half_period system clock cycles. A half_period of 0 acts as 1.
- R8: Between two transfers mw_cs stays low for at least 2*half_period cycles. busy is high from acceptance to the end of that gap, and a request made while busy is ignored.
- R9: After reset, mw_cs, mw_sk, mw_di, busy and done are 0 and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_op | input | 2 | 0 word read, 1 byte read, 2 write enable, 3 write disable |
| req_addr | input | ADDR_W+1 | Address; word reads use the low ADDR_W bits |
| req_quirk | input | 1 | Insert one extra clock pulse before the read data |
| half_period | input | DIV_W | System clocks per serial clock phase |
| busy | output | 1 | Transfer or inter-command gap in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 16 | Read result, right-aligned |
| mw_cs | output | 1 | Chip select to the memory, active high |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data into the memory |
| mw_do | input | 1 | Serial data out of the memory |

## Verification
The bench uses the default ADDR_W of 6 and DIV_W of 8. With these values it can sweep every one of the 64 word addresses and all 128 byte addresses, and compare each captured command stream and returned value with arithmetic patterns. A memory model in the bench can present its leading zero either early or one clock late. Pairing that with the quirk option on and off shows both the aligned result and the one-bit shift you get when the two do not match. Half-periods of 0, 1, 2 and 3 are run so the phase lengths and the chip-select gap can be measured directly.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    OP_RD_WORD = 2'd0,
    OP_RD_BYTE = 2'd1,
    OP_WR_EN   = 2'd2,
    OP_WR_DIS  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL, ST_GAP
  } state_e;

  typedef enum logic [1:0] {
    PH_CMD, PH_XTRA, PH_DATA
  } phase_e;
endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_period,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = (half_period == '0) ? '0 : half_period - 1'b1;
    tick = run && (cnt_q >= lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: with a half-period above one, ticks never come on adjacent cycles
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0 && $stable(half_period)) |=> !tick);
endmodule

// File: rtl/mw_cmd_build.sv
module mw_cmd_build
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int CMD_W = ADDR_W + 4,
  localparam int CNT_W = $clog2(CMD_W + 17)
) (
  input  logic [1:0]       op,
  input  logic [ADDR_W:0]  addr,
  output logic [CMD_W-1:0] vec,
  output logic [CNT_W-1:0] nbits,
  output logic             is_read,
  output logic             is_byte
);
  always_comb begin
    vec     = '0;
    nbits   = CNT_W'(ADDR_W + 3);
    is_read = 1'b0;
    is_byte = 1'b0;
    case (op_e'(op))
      OP_RD_WORD: begin
        vec     = {3'b110, addr[ADDR_W-1:0], 1'b0};
        is_read = 1'b1;
      end
      OP_RD_BYTE: begin
        vec     = {3'b110, addr};
        nbits   = CNT_W'(ADDR_W + 4);
        is_read = 1'b1;
        is_byte = 1'b1;
      end
      OP_WR_EN:  vec = {5'b10011, {(ADDR_W-1){1'b0}}};
      default:   vec = {5'b10000, {(ADDR_W-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int CMD_W = ADDR_W + 4,
  localparam int CNT_W = $clog2(CMD_W + 17)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req_valid,
  input  logic [CMD_W-1:0] vec,
  input  logic [CNT_W-1:0] nbits,
  input  logic             is_read,
  input  logic             is_byte,
  input  logic             quirk,
  input  logic             ee_do,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             cs,
  output logic             sk,
  output logic             di
);
  state_e           st_q, st_d;
  phase_e           ph_q, ph_d;
  logic [CMD_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, ndata;
  logic [15:0]      dreg_q, dreg_d, rd_d;
  logic             cs_d, sk_d, di_d, done_d, gap_q, gap_d;
  logic             rd_q, rd_nx, byte_q, byte_d, qk_q, qk_d;

  assign busy  = (st_q != ST_IDLE);
  assign ndata = byte_q ? CNT_W'(8) : CNT_W'(16);

  always_comb begin
    st_d = st_q;  ph_d = ph_q;  sreg_d = sreg_q;  cnt_d = cnt_q;
    dreg_d = dreg_q;  rd_d = rd_data;  cs_d = cs;  sk_d = sk;  di_d = di;
    done_d = 1'b0;  gap_d = gap_q;  rd_nx = rd_q;  byte_d = byte_q;  qk_d = qk_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d = ST_LEAD;  ph_d = PH_CMD;  sreg_d = vec;  cnt_d = nbits;
        dreg_d = '0;  cs_d = 1'b1;  di_d = vec[CMD_W-1];
        rd_nx = is_read;  byte_d = is_byte;  qk_d = quirk;
      end
      ST_LEAD: if (tick) begin
        sk_d = 1'b1;  st_d = ST_SHIFT;
      end
      ST_SHIFT: if (tick) begin
        if (!sk) begin
          sk_d = 1'b1;
          if (ph_q == PH_DATA) dreg_d = {dreg_q[14:0], ee_do};
        end else begin
          sk_d = 1'b0;
          if (cnt_q == CNT_W'(1)) begin
            di_d = 1'b0;
            case (ph_q)
              PH_CMD:
                if (rd_q && qk_q) begin ph_d = PH_XTRA; cnt_d = CNT_W'(1); end
                else if (rd_q)    begin ph_d = PH_DATA; cnt_d = ndata; end
                else              st_d = ST_TAIL;
              PH_XTRA: begin ph_d = PH_DATA; cnt_d = ndata; end
              default: st_d = ST_TAIL;
            endcase
          end else begin
            cnt_d = cnt_q - 1'b1;
            if (ph_q == PH_CMD) begin
              di_d   = sreg_q[CMD_W-2];
              sreg_d = sreg_q << 1;
            end
          end
        end
      end
      ST_TAIL: if (tick) begin
        cs_d = 1'b0;  done_d = 1'b1;  st_d = ST_GAP;  gap_d = 1'b0;
        if (rd_q) rd_d = dreg_q;
      end
      ST_GAP: if (tick) begin
        if (gap_q) st_d = ST_IDLE;
        else       gap_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ph_q <= PH_CMD;  sreg_q <= '0;  cnt_q <= '0;
      dreg_q <= '0;  rd_data <= '0;  cs <= 1'b0;  sk <= 1'b0;  di <= 1'b0;
      done <= 1'b0;  gap_q <= 1'b0;  rd_q <= 1'b0;  byte_q <= 1'b0;  qk_q <= 1'b0;
    end else begin
      st_q <= st_d;  ph_q <= ph_d;  sreg_q <= sreg_d;  cnt_q <= cnt_d;
      dreg_q <= dreg_d;  rd_data <= rd_d;  cs <= cs_d;  sk <= sk_d;  di <= di_d;
      done <= done_d;  gap_q <= gap_d;  rd_q <= rd_nx;  byte_q <= byte_d;  qk_q <= qk_d;
    end
  end

  // R6: data into the memory holds while the serial clock is high
  assert_di_stable_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> $stable(di));
  // R6: chip select moves only with the serial clock low
  assert_cs_sk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != $past(cs)) |-> (!sk && !$past(sk)));
  // R3: completion strobe is a single cycle
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: data line to the memory is low through the data phase
  assert_di_low_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && ph_q == PH_DATA) |-> !di);
  // R2: byte result carries a zero upper byte
  assert_byte_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_q && byte_q) |-> (rd_data[15:8] == 8'h00));
  // R4: the extra pulse belongs only to reads with the option set
  assert_xtra_only_quirk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_XTRA) |-> (qk_q && rd_q));
  // R8: chip select is low whenever the block is idle
  assert_idle_cs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cs);
endmodule

// File: rtl/mw_eeprom_rd.sv
module mw_eeprom_rd #(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 8,
  localparam int CMD_W = ADDR_W + 4,
  localparam int CNT_W = $clog2(CMD_W + 17)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_quirk,
  input  logic [DIV_W-1:0]  half_period,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  input  logic              mw_do
);
  logic             rst_m, rst_s, tick, is_read, is_byte;
  logic [CMD_W-1:0] vec;
  logic [CNT_W-1:0] nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  mw_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_s), .run(busy), .half_period(half_period), .tick(tick)
  );

  mw_cmd_build #(.ADDR_W(ADDR_W)) u_cmd (
    .op(req_op), .addr(req_addr), .vec(vec), .nbits(nbits),
    .is_read(is_read), .is_byte(is_byte)
  );

  mw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .tick(tick), .req_valid(req_valid),
    .vec(vec), .nbits(nbits), .is_read(is_read), .is_byte(is_byte),
    .quirk(req_quirk), .ee_do(mw_do), .busy(busy), .done(done),
    .rd_data(rd_data), .cs(mw_cs), .sk(mw_sk), .di(mw_di)
  );
endmodule

// File: tb/mw_eeprom_rd_test.sv
module mw_eeprom_rd_test;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [AW:0] req_addr = '0;
  logic        req_quirk = 1'b0;
  logic [7:0]  half_period = 8'd1;
  logic        busy, done, mw_cs, mw_sk, mw_di, mw_do;
  logic [15:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rises = 0, m_ncmd = 9, m_lag = 0, m_w = 16;
  logic [15:0] m_data = '0;
  logic [31:0] cap = '0;
  int hi_cnt = 0, last_hi = 0, lo_cnt = 0, last_lo = 0;

  always #10 clk = ~clk;

  mw_eeprom_rd #(.ADDR_W(AW), .DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_quirk(req_quirk), .half_period(half_period),
    .busy(busy), .done(done), .rd_data(rd_data), .mw_cs(mw_cs),
    .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
  );

  // memory model: leading zero then data, shifted out after each rising edge
  always @(posedge mw_cs) begin rises = 0; cap = '0; end
  always @(posedge mw_sk) if (mw_cs) begin
    if (rises < m_ncmd) cap = {cap[30:0], mw_di};
    rises = rises + 1;
  end
  always_comb begin
    int idx;
    idx = rises - m_ncmd - m_lag;
    mw_do = (idx >= 0 && idx < m_w) ? m_data[m_w-1-idx] : 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mw_sk) hi_cnt = hi_cnt + 1;
    else if (hi_cnt != 0) begin last_hi = hi_cnt; hi_cnt = 0; end
    if (!mw_cs) lo_cnt = lo_cnt + 1;
    else if (lo_cnt != 0) begin last_lo = lo_cnt; lo_cnt = 0; end
  end

  function automatic logic [15:0] wdat(int a);
    return 16'h9A31 ^ 16'(a * 16'h0407);
  endfunction
  function automatic logic [7:0] bdat(int a);
    return 8'h5B ^ 8'(a * 37);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_op(input int op, input int addr, input bit q, input int lag, input int hp);
    bit ok;
    int exp_rises, hpe;
    logic [15:0] prev, exp_d;
    logic [31:0] exp_vec;
    hpe = (hp == 0) ? 1 : hp;
    while (busy) @(negedge clk);
    half_period = 8'(hp);
    m_lag = lag;
    case (op)
      0: begin m_ncmd = AW + 3; m_w = 16; m_data = wdat(addr);
               exp_vec = 32'({3'b110, 6'(addr)}); end
      1: begin m_ncmd = AW + 4; m_w = 8; m_data = {8'h00, bdat(addr)};
               exp_vec = 32'({3'b110, 7'(addr)}); end
      2: begin m_ncmd = AW + 3; m_w = 0; exp_vec = 32'h130; end
      default: begin m_ncmd = AW + 3; m_w = 0; exp_vec = 32'h100; end
    endcase
    prev = rd_data;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = 7'(addr); req_quirk = q;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(ok);
    chk(ok, "R3 done strobe seen", ok, 1);
    if (!ok) return;
    exp_rises = m_ncmd + m_w + ((op < 2 && q) ? 1 : 0);
    chk(rises == exp_rises, "R4 pulse count", rises, exp_rises);
    if (op < 2) chk(cap == exp_vec, "R1 R2 command bits", cap, exp_vec);
    else        chk(cap == exp_vec, "R5 enable/disable bits", cap, exp_vec);
    chk(last_hi == hpe, "R7 high phase length", last_hi, hpe);
    if (op >= 2) chk(rd_data == prev, "R5 rd_data unchanged", rd_data, prev);
    else begin
      exp_d = (lag - int'(q) == 1) ? (m_data >> 1) : m_data;
      if (op == 1) chk(rd_data == exp_d, "R2 byte data", rd_data, exp_d);
      else         chk(rd_data == exp_d, "R1 R3 word data", rd_data, exp_d);
    end
    @(negedge clk);
    chk(!done, "R3 done single cycle", done, 0);
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({mw_cs, mw_sk, mw_di, busy, done} == 5'b0 && rd_data == 16'h0, "R9 reset outputs",
        {mw_cs, mw_sk, mw_di, busy, done, rd_data}, 0);

    for (int a = 0; a < 64; a++) run_op(0, a, 1'b0, 0, 1);       // R1
    for (int a = 0; a < 64; a++) run_op(0, a, 1'b1, 1, 2);       // R4 aligned
    for (int a = 0; a < 128; a++) run_op(1, a, 1'b0, 0, 1);      // R2
    for (int a = 0; a < 16; a++) run_op(1, a * 7 + 3, 1'b1, 1, 3);
    run_op(0, 21, 1'b0, 1, 1);   // R4 late zero without option: shifted by one
    run_op(2, 0, 1'b1, 0, 2);    // R5 enable, option ignored
    run_op(3, 0, 1'b0, 0, 1);    // R5 disable
    run_op(0, 63, 1'b0, 0, 0);   // R7 half_period 0 acts as 1

    // R8 busy ignore: second request during transfer
    run_op(0, 5, 1'b0, 0, 1);
    begin
      logic [15:0] held;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_addr = 7'd40; req_quirk = 1'b0;
      m_data = wdat(40); m_lag = 0; m_ncmd = AW + 3; m_w = 16;
      @(negedge clk);
      req_valid = 1'b0; held = wdat(40);
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd1; req_addr = 7'd9;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(ok);
      chk(ok && rd_data == held, "R8 request while busy ignored", rd_data, held);
      chk(cap == 32'({3'b110, 6'd40}), "R8 command unaffected", cap, 32'({3'b110, 6'd40}));
      repeat (30) @(negedge clk);
      chk(!mw_cs && !busy, "R8 no extra transfer", {mw_cs, busy}, 0);
    end

    // R8 gap with a request held high back to back
    half_period = 8'd3;
    m_ncmd = AW + 3; m_w = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2;
    wait_done(ok);
    wait_done(ok);
    req_valid = 1'b0;
    chk(ok && last_lo >= 6, "R8 chip select gap", last_lo, 6);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule